// File: doc/BRIEF.md
# Serial Register-Access Command Decoder

This block sits behind a four-wire synchronous serial port and gives a host byte-level command access to eight internal 8-bit registers. Every byte the host sends while select is held low is either an opcode, the data byte of a write, or a dummy byte that clocks out fetched data. Reads happen in two steps. A select opcode first copies one or two register values into two staging buffers, A and B, and raises a data-available flag. A separate fetch opcode then shifts the staged bytes out on the serial output.

The serial pins are brought into the system clock domain through synchronizers, so the serial clock must run well below the system clock. The link uses clock mode 0 with the most significant bit first. The host samples the output on the rising serial clock edge, and the block changes the output after a falling edge. During every opcode slot and every write-data slot the block sends its status byte, so a host learns the flags while it issues its next command.

Top module: `sercmd_decoder`

## Requirements
- R1: The status byte carries DAV in bit 7, RD2 in bit 6 and RDY in bit 5, with bits 4..0 zero. It is shifted out during every opcode slot and every write-data slot. Its value after reset is 20h. RD2 never reads 1 while DAV is 0.
- R2: An opcode in 40h..47h copies register[opcode bits 2:0] into buffer A, sets buffer B to FFh, sets DAV to 1 and sets RD2 to 0.
- R3: An opcode in 60h..66h copies register[a] into buffer A and register[a+1] into buffer B, where a is opcode bits 2:0. It sets both DAV and RD2 to 1.
- R4: After opcode F8h the next byte slot shifts out buffer A. After F9h the next two slots shift out A and then B. Both opcodes leave RDY unchanged and act whether or not DAV is set. Without DAV they send the buffers as last staged.
- R5: With RD2 at 0, DAV clears on the eighth rising serial clock edge of the first fetched byte. With RD2 at 1, DAV clears on the eighth rising edge of the second fetched byte, so a single-byte fetch leaves it set. RD2 clears together with DAV.
- R6: An opcode in C0h..DFh stores the following byte into register[opcode bits 2:0]; bits 4:3 are don't-care. RDY reads 0 from the end of the opcode until the data byte completes, including in the status sent during the data slot.
- R7: Opcode 67h and every opcode outside the ranges above change neither the buffers nor the status byte.
- R8: Transfers are MSB first in clock mode 0. Raising select clears the bit counter and returns to the opcode slot. A partial byte has no effect, and a write left without its data byte is dropped, with RDY back at 1.
- R9: Bytes received in a fetch slot or a write-data slot are never decoded as opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| ser_din | input | 1 | Serial data from the host |
| ser_sel_n | input | 1 | Active-low select; a high level ends the transfer |
| ser_dout | output | 1 | Serial data to the host |

## Verification
The hardest state to reach is a two-byte staging read out by a one-byte fetch, because DAV must stay high past that fetch. A single-byte fetch of a 60h-range selection is therefore followed by a status slot that must still show E0h, then by a two-byte fetch that finally clears the flag. The cases around select are also hard to reach. They need select raised partway through an opcode byte and again between a write opcode and its data, and each is confirmed by reading back the status and the untouched register in a fresh transfer. A behavioural model in the bench predicts every byte on the serial output and compares it with what is received.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NREG   = 1 << ADDR_W;

    // Status byte bit positions (host decodes these)
    localparam int ST_AVAIL = 7;
    localparam int ST_PAIR  = 6;
    localparam int ST_READY = 5;

    typedef enum logic [2:0] {
        K_NONE,
        K_STAGE1,
        K_STAGE2,
        K_FETCH1,
        K_FETCH2,
        K_WRITE
    } op_kind_e;

    typedef enum logic [1:0] {
        SLOT_CMD,
        SLOT_WDATA,
        SLOT_OUT_A,
        SLOT_OUT_B
    } slot_e;

    function automatic op_kind_e classify(input logic [BYTE_W-1:0] op);
        op_kind_e k;
        if (op[7:3] == 5'b01000)
            k = K_STAGE1;
        else if (op[7:3] == 5'b01100 && op[2:0] != 3'b111)
            k = K_STAGE2;
        else if (op == 8'hF8)
            k = K_FETCH1;
        else if (op == 8'hF9)
            k = K_FETCH2;
        else if (op[7:5] == 3'b110)
            k = K_WRITE;
        else
            k = K_NONE;
        return k;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic avail,
                                                      input logic pair,
                                                      input logic ready);
        logic [BYTE_W-1:0] s;
        s           = '0;
        s[ST_AVAIL] = avail;
        s[ST_PAIR]  = pair & avail;
        s[ST_READY] = ready;
        return s;
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            s_d.pipe[k] = s_q.pipe[k-1];
        end
        s_d.prev    = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe <= {STAGES{RST_VAL}};
            s_q.prev <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.pipe[STAGES-1];
    assign rise  = level & ~s_q.prev;
    assign fall  = ~level & s_q.prev;

endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi,
    input  logic [BW-1:0] load_byte,
    output logic          byte_done,
    output logic [BW-1:0] rx_byte,
    output logic          sdo
);

    localparam int CW = $clog2(BW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-1:0] rx;
        logic [BW-1:0] tx;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        byte_done = sel && sck_rise && (s_q.cnt == CW'(BW - 1));
        rx_byte   = {s_q.rx[BW-2:0], sdi};
        if (!sel) begin
            s_d.cnt = '0;
            s_d.tx  = load_byte;
        end else begin
            if (sck_rise) begin
                s_d.rx  = rx_byte;
                s_d.cnt = byte_done ? '0 : s_q.cnt + 1'b1;
            end
            if (byte_done) begin
                s_d.tx = load_byte;
            end else if (sck_fall && s_q.cnt != '0) begin
                s_d.tx = {s_q.tx[BW-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo = s_q.tx[BW-1];

endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
    import sercmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] tx_next,
    output logic [BYTE_W-1:0] status,
    output logic              cmd_slot
);

    typedef struct packed {
        slot_e                        slot;
        logic                         two;
        logic [ADDR_W-1:0]            waddr;
        logic [BYTE_W-1:0]            buf_a;
        logic [BYTE_W-1:0]            buf_b;
        logic                         avail;
        logic                         pair;
        logic                         ready;
        logic [NREG-1:0][BYTE_W-1:0]  regs;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] addr_nxt;
    op_kind_e          kind;

    always_comb begin
        c_d      = c_q;
        addr     = rx_byte[ADDR_W-1:0];
        addr_nxt = addr + 1'b1;
        kind     = classify(rx_byte);

        if (!sel) begin
            c_d.slot  = SLOT_CMD;
            c_d.two   = 1'b0;
            c_d.ready = 1'b1;
        end else if (byte_done) begin
            unique case (c_q.slot)
                SLOT_CMD: begin
                    unique case (kind)
                        K_STAGE1: begin
                            c_d.buf_a = c_q.regs[addr];
                            c_d.buf_b = FILL;
                            c_d.avail = 1'b1;
                            c_d.pair  = 1'b0;
                        end
                        K_STAGE2: begin
                            c_d.buf_a = c_q.regs[addr];
                            c_d.buf_b = c_q.regs[addr_nxt];
                            c_d.avail = 1'b1;
                            c_d.pair  = 1'b1;
                        end
                        K_FETCH1: begin
                            c_d.slot = SLOT_OUT_A;
                            c_d.two  = 1'b0;
                        end
                        K_FETCH2: begin
                            c_d.slot = SLOT_OUT_A;
                            c_d.two  = 1'b1;
                        end
                        K_WRITE: begin
                            c_d.slot  = SLOT_WDATA;
                            c_d.waddr = addr;
                            c_d.ready = 1'b0;
                        end
                        default: ;
                    endcase
                end
                SLOT_WDATA: begin
                    c_d.regs[c_q.waddr] = rx_byte;
                    c_d.ready           = 1'b1;
                    c_d.slot            = SLOT_CMD;
                end
                SLOT_OUT_A: begin
                    if (c_q.avail && !c_q.pair) begin
                        c_d.avail = 1'b0;
                    end
                    c_d.slot = c_q.two ? SLOT_OUT_B : SLOT_CMD;
                end
                SLOT_OUT_B: begin
                    if (c_q.avail && c_q.pair) begin
                        c_d.avail = 1'b0;
                        c_d.pair  = 1'b0;
                    end
                    c_d.slot = SLOT_CMD;
                    c_d.two  = 1'b0;
                end
                default: ;
            endcase
        end

        unique case (c_d.slot)
            SLOT_OUT_A: tx_next = c_d.buf_a;
            SLOT_OUT_B: tx_next = c_d.buf_b;
            default:    tx_next = pack_status(c_d.avail, c_d.pair, c_d.ready);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.ready <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign status   = pack_status(c_q.avail, c_q.pair, c_q.ready);
    assign cmd_slot = (c_q.slot == SLOT_CMD);

endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic ser_sel_n,
    output logic ser_dout
);

    localparam int NPIN = 3;
    localparam int P_DIN = 0;
    localparam int P_CLK = 1;
    localparam int P_SEL = 2;

    logic [NPIN-1:0]   pin_lvl, pin_rise, pin_fall;
    logic              sel_w;
    logic              byte_done_w;
    logic [BYTE_W-1:0] rx_byte_w;
    logic [BYTE_W-1:0] tx_next_w;
    logic [BYTE_W-1:0] status_w;
    logic              cmd_slot_w;

    sercmd_sync #(
        .W       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_sel_n, ser_clk, ser_din}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign sel_w = ~pin_lvl[P_SEL];

    sercmd_shift #(
        .BW (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_w),
        .sck_rise  (pin_rise[P_CLK]),
        .sck_fall  (pin_fall[P_CLK]),
        .sdi       (pin_lvl[P_DIN]),
        .load_byte (tx_next_w),
        .byte_done (byte_done_w),
        .rx_byte   (rx_byte_w),
        .sdo       (ser_dout)
    );

    sercmd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_w),
        .byte_done (byte_done_w),
        .rx_byte   (rx_byte_w),
        .tx_next   (tx_next_w),
        .status    (status_w),
        .cmd_slot  (cmd_slot_w)
    );

endmodule

// File: rtl/sercmd_checker.sv
module sercmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_done,
    input logic       cmd_slot,
    input logic [7:0] rx_byte,
    input logic [7:0] status
);

    AST_PAIR_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7] |-> !status[6]); // R1

    AST_STAGE1_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cmd_slot && rx_byte[7:3] == 5'b01000)
        |=> (status[7] && !status[6])); // R2

    AST_STAGE2_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cmd_slot && rx_byte[7:3] == 5'b01100 && rx_byte[2:0] != 3'b111)
        |=> (status[7] && status[6])); // R3

    AST_FETCH_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cmd_slot && (rx_byte == 8'hF8 || rx_byte == 8'hF9))
        |=> (status[5] == $past(status[5]))); // R4

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cmd_slot && rx_byte[7:5] == 3'b110)
        |=> !status[5]); // R6

    AST_UNUSED_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cmd_slot && (rx_byte == 8'h67 || rx_byte == 8'h00 || rx_byte == 8'h55))
        |=> (status == $past(status))); // R7

endmodule

bind sercmd_decoder sercmd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done_w),
    .cmd_slot  (cmd_slot_w),
    .rx_byte   (rx_byte_w),
    .status    (status_w)
);

// File: tb/sercmd_decoder_test.sv
module sercmd_decoder_test;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sel_n = 1'b1;
    logic sdo;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sercmd_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (sck),
        .ser_din   (sdi),
        .ser_sel_n (sel_n),
        .ser_dout  (sdo)
    );

    // Behavioural reference model
    logic [7:0] m_regs [8];
    logic [7:0] m_a, m_b;
    bit         m_dav, m_rd2, m_rdy, m_two;
    int         m_slot;   // 0 opcode, 1 write data, 2 first fetch, 3 second fetch
    int         m_waddr;

    function automatic logic [7:0] m_status();
        return {m_dav, m_dav & m_rd2, m_rdy, 5'b00000};
    endfunction

    function automatic logic [7:0] m_expect();
        if (m_slot == 2) return m_a;
        if (m_slot == 3) return m_b;
        return m_status();
    endfunction

    task automatic m_apply(input logic [7:0] b);
        int ad;
        ad = int'(b & 8'h07);
        case (m_slot)
            0: begin
                if (b >= 8'h40 && b <= 8'h47) begin
                    m_a = m_regs[ad]; m_b = 8'hFF; m_dav = 1; m_rd2 = 0;
                end else if (b >= 8'h60 && b <= 8'h66) begin
                    m_a = m_regs[ad]; m_b = m_regs[ad + 1]; m_dav = 1; m_rd2 = 1;
                end else if (b == 8'hF8) begin
                    m_slot = 2; m_two = 0;
                end else if (b == 8'hF9) begin
                    m_slot = 2; m_two = 1;
                end else if (b >= 8'hC0 && b <= 8'hDF) begin
                    m_slot = 1; m_waddr = ad; m_rdy = 0;
                end
            end
            1: begin
                m_regs[m_waddr] = b; m_rdy = 1; m_slot = 0;
            end
            2: begin
                if (m_dav && !m_rd2) m_dav = 0;
                m_slot = m_two ? 3 : 0;
            end
            default: begin
                if (m_dav && m_rd2) begin m_dav = 0; m_rd2 = 0; end
                m_slot = 0; m_two = 0;
            end
        endcase
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic shift_byte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sdi = t[i];
            repeat (HALF) @(negedge clk);
            r[i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] t, input string req, output logic [7:0] got);
        logic [7:0] exp;
        exp = m_expect();
        shift_byte(t, got);
        check(req, got, exp);
        m_apply(t);
    endtask

    task automatic open_frame();
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        m_slot = 0; m_two = 0; m_rdy = 1;
    endtask

    task automatic partial(input logic [7:0] t, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = t[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] g;
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        m_a = 0; m_b = 0; m_dav = 0; m_rd2 = 0; m_rdy = 1; m_two = 0;
        m_slot = 0; m_waddr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset status seen in the first opcode slot
        open_frame();
        xfer(8'h00, "R1", g);
        check("R1", g, 8'h20);
        close_frame();

        // R6: write all registers, varying the don't-care bits 4:3
        for (int i = 0; i < 8; i++) begin
            open_frame();
            xfer(8'hC0 | 8'((i % 4) << 3) | 8'(i), "R6", g);
            xfer(8'h13 + 8'(i * 37), "R6", g);
            check("R6", g, 8'h00);
            close_frame();
        end

        // R2/R4/R5: single select, single fetch, DAV cleared
        open_frame();
        xfer(8'h43, "R2", g);
        xfer(8'hF8, "R4", g);
        check("R2", g, 8'hA0);
        xfer(8'h00, "R4", g);
        check("R2", g, 8'h13 + 8'(3 * 37));
        xfer(8'h00, "R5", g);
        check("R5", g, 8'h20);
        close_frame();

        // R2/R5: single select, double fetch, B is FFh
        open_frame();
        xfer(8'h45, "R2", g);
        xfer(8'hF9, "R4", g);
        xfer(8'h00, "R4", g);
        xfer(8'h00, "R2", g);
        check("R2", g, 8'hFF);
        xfer(8'h00, "R5", g);
        close_frame();

        // R3/R5: pair select at top address, one-byte fetch keeps DAV
        open_frame();
        xfer(8'h66, "R3", g);
        xfer(8'hF8, "R3", g);
        check("R3", g, 8'hE0);
        xfer(8'h00, "R4", g);
        xfer(8'hF9, "R5", g);
        check("R5", g, 8'hE0);
        xfer(8'h00, "R3", g);
        xfer(8'h00, "R3", g);
        check("R3", g, 8'h13 + 8'(7 * 37));
        xfer(8'h00, "R5", g);
        check("R5", g, 8'h20);
        close_frame();

        // R3: pair select at address 0, fetch in a later frame
        open_frame();
        xfer(8'h60, "R3", g);
        close_frame();
        open_frame();
        xfer(8'hF9, "R3", g);
        xfer(8'h00, "R3", g);
        xfer(8'h00, "R3", g);
        xfer(8'h00, "R5", g);
        close_frame();

        // R7: unlisted opcodes leave buffers and status alone
        open_frame();
        xfer(8'h42, "R7", g);
        xfer(8'h67, "R7", g);
        xfer(8'h00, "R7", g);
        xfer(8'h55, "R7", g);
        xfer(8'h9C, "R7", g);
        xfer(8'hE7, "R7", g);
        check("R7", g, 8'hA0);
        xfer(8'hF9, "R7", g);
        xfer(8'h00, "R7", g);
        xfer(8'h00, "R7", g);
        check("R7", g, 8'hFF);
        close_frame();

        // R4: fetch without DAV repeats last staged buffers
        open_frame();
        xfer(8'hF8, "R4", g);
        xfer(8'h00, "R4", g);
        check("R4", g, 8'h13 + 8'(2 * 37));
        xfer(8'h00, "R4", g);
        close_frame();

        // R9: opcodes inside fetch slots are not decoded
        open_frame();
        xfer(8'hF9, "R9", g);
        xfer(8'h43, "R9", g);
        xfer(8'hC5, "R9", g);
        xfer(8'h00, "R9", g);
        check("R9", g, 8'h20);
        close_frame();

        // R9: write data equal to an opcode is stored as data
        open_frame();
        xfer(8'hC1, "R9", g);
        xfer(8'hF9, "R9", g);
        xfer(8'h41, "R9", g);
        xfer(8'hF8, "R9", g);
        xfer(8'h00, "R9", g);
        check("R9", g, 8'hF9);
        close_frame();

        // R8: partial byte then deselect has no effect
        open_frame();
        partial(8'h43, 5);
        close_frame();
        open_frame();
        xfer(8'h00, "R8", g);
        check("R8", g, 8'h20);
        close_frame();

        // R8: write opcode abandoned by deselect
        open_frame();
        xfer(8'hC2, "R8", g);
        close_frame();
        open_frame();
        xfer(8'h42, "R8", g);
        check("R8", g, 8'h20);
        xfer(8'hF8, "R8", g);
        xfer(8'h00, "R8", g);
        check("R8", g, 8'h13 + 8'(2 * 37));
        close_frame();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule